// File: doc/BRIEF.md
# Multidrop Serial Core with Ninth-Bit Addressing

This block is an asynchronous serial transmitter and receiver for shared multidrop lines, where one master talks to many stations over a single pair. Each character can carry an extra ninth bit. In network mode that bit tells listeners whether the character is a station address or plain data. The receiver compares every address character against a stored 8-bit station number and flags a hit. A hit can also raise a one-cycle interrupt.

Outside network mode the core is an ordinary serial port with 8 data bits, or 9 when the word-length control is set. Bit timing comes from an external enable, `baud_tick`, which pulses 16 times per bit period. The receiver samples each bit once, in the middle of the bit. The transmit output has a separate output-enable. The pad can then release the line, so a passive slave never fights the active talker.

Top module: `mduart_net9`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then any ninth bit, then one high stop bit. Each bit lasts 16 `baud_tick` pulses.
- R2: With `wlen9` clear and network addressing not in effect for a direction, that direction uses 8 data bits and `rx_data[8]` reads 0. With `wlen9` set, frames carry 9 data bits: `tx_data[8]` is sent after bit 7 and returns in `rx_data[8]`. `tx_busy` stays high for 160 ticks on 10-bit frames and 176 ticks on 11-bit frames.
- R3: The ninth transmitted bit becomes an address marker only when `net_en` and `tx9_en` are both set. `tx9_en` with `net_en` clear has no effect.
- R4: Received characters are classed as address or data only when `net_en` and `rx9_en` are both set. `rx9_en` with `net_en` clear has no effect, and `rx_is_addr` stays 0.
- R5: A ninth bit equal to `addr_pol` marks an address. The transmitter sends `addr_pol` when `tx_addr`=1 and the inverse when `tx_addr`=0. `rx_data[8]` holds the raw ninth bit.
- R6: `rx_match` is 1 exactly when the character is an address and `rx_data[7:0]` equals `station_addr`. A data character never matches.
- R7: `irq` pulses for one cycle, together with `rx_valid`, only for a matching address character while `irq_en` is set.
- R8: `txd_oe` follows `drv_en`. While it is 0 the line is left released and nothing is received in loopback, but transmit timing still runs.
- R9: A low stop bit sets `rx_frame_err` on that character, and the character is still delivered. A good stop bit clears the flag.
- R10: After reset: `tx_busy`=0, `txd`=1, `rx_valid`=0, `irq`=0.
- R11: A `tx_start` while `tx_busy` is high is ignored. The frame in flight keeps its data and length.
- R12: `rx_valid` is a single-cycle pulse per received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse, 16 per bit period |
| net_en | input | 1 | Network (multidrop) mode |
| tx9_en | input | 1 | Ninth bit as address marker on transmit |
| rx9_en | input | 1 | Ninth bit as address marker on receive |
| wlen9 | input | 1 | 9 data bits when marker mode is off |
| drv_en | input | 1 | Transmit pin driver enable |
| addr_pol | input | 1 | Ninth-bit value that marks an address |
| station_addr | input | 8 | Own station address |
| irq_en | input | 1 | Receive interrupt enable |
| tx_start | input | 1 | Start a character when idle |
| tx_addr | input | 1 | Send the character as an address |
| tx_data | input | 9 | Character to send |
| tx_busy | output | 1 | Transmitter active |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Pad output enable for txd |
| rxd | input | 1 | Serial data in |
| rx_valid | output | 1 | Character received (pulse) |
| rx_data | output | 9 | Received character |
| rx_is_addr | output | 1 | Character was an address |
| rx_match | output | 1 | Address equals station_addr |
| rx_frame_err | output | 1 | Stop bit was low |
| irq | output | 1 | Address-match interrupt pulse |

## Verification
The bench sweeps every byte value in 8-bit mode. It then sweeps strided value sets through 9-bit data mode, both address polarities, and the mixed settings where a 9-bit enable is set without network mode. A design that miscounts bits changes the `tx_busy` length or shifts the returned data. One that ignores the network gating flags plain characters as addresses. Manually driven frames test a low stop bit and an address with the wrong ninth-bit value; a faulty core would drop the errored character or match a data byte. The bench also checks that a start request mid-frame is ignored and that a released driver delivers nothing.

// File: rtl/mduart_pkg.sv
package mduart_pkg;

  typedef enum logic [1:0] {
    WF_BYTE      = 2'd0,
    WF_NINE_DATA = 2'd1,
    WF_NINE_ADDR = 2'd2
  } wfmt_e;

  // Marker mode needs network mode; word length applies otherwise.
  function automatic wfmt_e sel_fmt(input logic net, input logic nine, input logic wl9);
    if (net && nine)  return WF_NINE_ADDR;
    else if (wl9)     return WF_NINE_DATA;
    else              return WF_BYTE;
  endfunction

  function automatic logic [3:0] data_bits(input wfmt_e f);
    return (f == WF_BYTE) ? 4'd8 : 4'd9;
  endfunction

endpackage

// File: rtl/mduart_tx.sv
module mduart_tx
  import mduart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  wfmt_e      fmt,
  input  logic [8:0] word,
  output logic       busy,
  output logic       bit_o
);
  localparam int CW = $clog2(OVS);
  localparam int FW = 11;
  localparam int LW = $clog2(FW + 1);

  logic          busy_q, busy_n;
  logic [FW-1:0] sh_q, sh_n;
  logic [LW-1:0] left_q, left_n;
  logic [CW-1:0] tc_q, tc_n;

  always_comb begin
    busy_n = busy_q;
    sh_n   = sh_q;
    left_n = left_q;
    tc_n   = tc_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        tc_n   = '0;
        if (fmt == WF_BYTE) begin
          sh_n   = {2'b11, word[7:0], 1'b0};
          left_n = LW'(10);
        end else begin
          sh_n   = {1'b1, word, 1'b0};
          left_n = LW'(11);
        end
      end
    end else if (tick) begin
      if (tc_q == CW'(OVS - 1)) begin
        tc_n   = '0;
        sh_n   = {1'b1, sh_q[FW-1:1]};
        left_n = left_q - LW'(1);
        if (left_q == LW'(1)) busy_n = 1'b0;
      end else begin
        tc_n = tc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tc_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sh_q   <= sh_n;
      left_q <= left_n;
      tc_q   <= tc_n;
    end
  end

  assign busy  = busy_q;
  assign bit_o = busy_q ? sh_q[0] : 1'b1;

  // R1: every frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !bit_o);
  // R1: the last bit before the transmitter goes idle is a high stop bit
  p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bit_o));
  // R11: a start request while busy does not reload the frame length
  p_no_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> (left_q == $past(left_q)));

endmodule

// File: rtl/mduart_rx.sv
module mduart_rx
  import mduart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  wfmt_e      fmt,
  output logic       done,
  output logic [8:0] word,
  output logic       stop_bad,
  output wfmt_e      word_fmt
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rst_e;

  logic          s1_q, s2_q;
  rst_e          st_q, st_n;
  logic [CW-1:0] tc_q, tc_n;
  logic [3:0]    bi_q, bi_n;
  logic [8:0]    sh_q, sh_n;
  wfmt_e         fmt_q, fmt_n;
  logic          done_q, done_n;
  logic [8:0]    word_q, word_n;
  logic          bad_q, bad_n;

  always_comb begin
    st_n   = st_q;
    tc_n   = tc_q;
    bi_n   = bi_q;
    sh_n   = sh_q;
    fmt_n  = fmt_q;
    done_n = 1'b0;
    word_n = word_q;
    bad_n  = bad_q;
    if (tick) begin
      unique case (st_q)
        R_IDLE: begin
          if (!s2_q) begin
            st_n  = R_START;
            tc_n  = '0;
            sh_n  = '0;
            fmt_n = fmt;
          end
        end
        R_START: begin
          if (tc_q == CW'(HALF - 1)) begin
            tc_n = '0;
            bi_n = '0;
            st_n = s2_q ? R_IDLE : R_DATA;
          end else begin
            tc_n = tc_q + CW'(1);
          end
        end
        R_DATA: begin
          if (tc_q == CW'(OVS - 1)) begin
            tc_n       = '0;
            sh_n[bi_q] = s2_q;
            if (bi_q == data_bits(fmt_q) - 4'd1) st_n = R_STOP;
            else                                 bi_n = bi_q + 4'd1;
          end else begin
            tc_n = tc_q + CW'(1);
          end
        end
        default: begin
          if (tc_q == CW'(OVS - 1)) begin
            tc_n   = '0;
            st_n   = R_IDLE;
            done_n = 1'b1;
            word_n = sh_q;
            bad_n  = !s2_q;
          end else begin
            tc_n = tc_q + CW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      st_q   <= R_IDLE;
      tc_q   <= '0;
      bi_q   <= '0;
      sh_q   <= '0;
      fmt_q  <= WF_BYTE;
      done_q <= 1'b0;
      word_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      st_q   <= st_n;
      tc_q   <= tc_n;
      bi_q   <= bi_n;
      sh_q   <= sh_n;
      fmt_q  <= fmt_n;
      done_q <= done_n;
      word_q <= word_n;
      bad_q  <= bad_n;
    end
  end

  assign done     = done_q;
  assign word     = word_q;
  assign stop_bad = bad_q;
  assign word_fmt = fmt_q;

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: a completed character always leaves the receiver idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == R_IDLE));

endmodule

// File: rtl/mduart_addr_filter.sv
module mduart_addr_filter
  import mduart_pkg::*;
(
  input  wfmt_e      fmt,
  input  logic [8:0] word,
  input  logic       pol,
  input  logic [7:0] station,
  output logic       is_addr,
  output logic       hit
);
  always_comb begin
    is_addr = (fmt == WF_NINE_ADDR) && (word[8] == pol);
    hit     = is_addr && (word[7:0] == station);
  end
endmodule

// File: rtl/mduart_net9.sv
module mduart_net9
  import mduart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       net_en,
  input  logic       tx9_en,
  input  logic       rx9_en,
  input  logic       wlen9,
  input  logic       drv_en,
  input  logic       addr_pol,
  input  logic [7:0] station_addr,
  input  logic       irq_en,
  input  logic       tx_start,
  input  logic       tx_addr,
  input  logic [8:0] tx_data,
  output logic       tx_busy,
  output logic       txd,
  output logic       txd_oe,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [8:0] rx_data,
  output logic       rx_is_addr,
  output logic       rx_match,
  output logic       rx_frame_err,
  output logic       irq
);
  wfmt_e      fmt_tx, fmt_rx, rx_wfmt;
  logic [8:0] tx_word;
  logic       rx_done, rx_bad, f_is_addr, f_hit;
  logic [8:0] rx_word;

  always_comb begin
    fmt_tx  = sel_fmt(net_en, tx9_en, wlen9);
    fmt_rx  = sel_fmt(net_en, rx9_en, wlen9);
    tx_word = (fmt_tx == WF_NINE_ADDR) ? {~(tx_addr ^ addr_pol), tx_data[7:0]} : tx_data;
  end

  mduart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start(tx_start),
    .fmt(fmt_tx), .word(tx_word), .busy(tx_busy), .bit_o(txd)
  );

  assign txd_oe = drv_en;

  mduart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .fmt(fmt_rx),
    .done(rx_done), .word(rx_word), .stop_bad(rx_bad), .word_fmt(rx_wfmt)
  );

  mduart_addr_filter u_flt (
    .fmt(rx_wfmt), .word(rx_word), .pol(addr_pol), .station(station_addr),
    .is_addr(f_is_addr), .hit(f_hit)
  );

  logic       val_q, val_n, irq_q, irq_n;
  logic       adr_q, adr_n, mat_q, mat_n, fer_q, fer_n;
  logic [8:0] dat_q, dat_n;

  always_comb begin
    val_n = rx_done;
    irq_n = rx_done && f_hit && irq_en;
    adr_n = adr_q;
    mat_n = mat_q;
    fer_n = fer_q;
    dat_n = dat_q;
    if (rx_done) begin
      adr_n = f_is_addr;
      mat_n = f_hit;
      fer_n = rx_bad;
      dat_n = rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      irq_q <= 1'b0;
      adr_q <= 1'b0;
      mat_q <= 1'b0;
      fer_q <= 1'b0;
      dat_q <= '0;
    end else begin
      val_q <= val_n;
      irq_q <= irq_n;
      adr_q <= adr_n;
      mat_q <= mat_n;
      fer_q <= fer_n;
      dat_q <= dat_n;
    end
  end

  assign rx_valid     = val_q;
  assign irq          = irq_q;
  assign rx_is_addr   = adr_q;
  assign rx_match     = mat_q;
  assign rx_frame_err = fer_q;
  assign rx_data      = dat_q;

  // R7: the interrupt only accompanies a delivered, matching character
  p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_valid && rx_match));
  // R6: a match is only ever reported on an address character
  p_match_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_match |-> rx_is_addr);
  // R12: delivery is a single-cycle pulse
  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: tb/tb_mduart_net9.sv
module tb_mduart_net9;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tick;
  logic       net_en, tx9_en, rx9_en, wlen9, drv_en, addr_pol, irq_en;
  logic [7:0] station;
  logic       tx_start, tx_addr;
  logic [8:0] tx_data;
  logic       tx_busy, txd, txd_oe, rxd;
  logic       rx_valid, rx_is_addr, rx_match, rx_frame_err, irq;
  logic [8:0] rx_data;
  logic       loop, drv_line;

  assign rxd = loop ? (txd_oe ? txd : 1'b1) : drv_line;

  mduart_net9 dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .net_en(net_en), .tx9_en(tx9_en),
    .rx9_en(rx9_en), .wlen9(wlen9), .drv_en(drv_en), .addr_pol(addr_pol),
    .station_addr(station), .irq_en(irq_en), .tx_start(tx_start), .tx_addr(tx_addr),
    .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd), .txd_oe(txd_oe), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
    .rx_match(rx_match), .rx_frame_err(rx_frame_err), .irq(irq)
  );

  int nvec = 0;
  int nbad = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // 0 = byte, 1 = nine data bits, 2 = address marker
  function automatic int fmt_of(input logic net, input logic nine, input logic wl);
    if (net && nine) return 2;
    if (wl) return 1;
    return 0;
  endfunction

  task automatic set_cfg(input logic n, input logic t9, input logic r9, input logic wl,
                         input logic pol, input logic ie);
    @(negedge clk);
    net_en = n; tx9_en = t9; rx9_en = r9; wlen9 = wl; addr_pol = pol; irq_en = ie;
  endtask

  // Send one character in loopback and check what comes back.
  task automatic run_char(input logic [8:0] d, input logic a, input bit expect_rx, input bit poke);
    int  f;
    int  bcyc;
    bit  got;
    logic [8:0] e_dat;
    logic e_adr, e_mat, e_irq;
    logic [8:0] c_dat;
    logic c_adr, c_mat, c_irq, c_fer;
    f = fmt_of(net_en, tx9_en, wlen9);
    if (f == 0)      e_dat = {1'b0, d[7:0]};
    else if (f == 1) e_dat = d;
    else             e_dat = {(a ? addr_pol : ~addr_pol), d[7:0]};
    e_adr = (f == 2) && a;
    e_mat = e_adr && (d[7:0] == station);
    e_irq = e_mat && irq_en;
    @(negedge clk);
    tx_data = d; tx_addr = a; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    bcyc = 0; got = 1'b0;
    c_dat = '0; c_adr = 0; c_mat = 0; c_irq = 0; c_fer = 0;
    for (int i = 0; i < 600 && (tx_busy || (expect_rx && !got)); i++) begin
      if (tx_busy) bcyc++;
      if (rx_valid) begin
        if (got) chk("R12 double valid", 1, 0);
        got = 1'b1;
        c_dat = rx_data; c_adr = rx_is_addr; c_mat = rx_match; c_irq = irq; c_fer = rx_frame_err;
      end
      if (poke && i == 40) begin tx_data = ~d; tx_addr = ~a; tx_start = 1'b1; end
      else tx_start = 1'b0;
      @(negedge clk);
    end
    tx_start = 1'b0;
    chk("R2 busy length", 32'(bcyc), 32'((f == 0) ? 160 : 176));
    if (!expect_rx) begin
      chk("R8 nothing received when released", 32'(got), 0);
    end else begin
      chk("R1 R2 R5 data returned", 32'(got ? c_dat : 9'h1FF), 32'(e_dat));
      chk("R3 R4 address class", 32'(c_adr), 32'(e_adr));
      chk("R6 match", 32'(c_mat), 32'(e_mat));
      chk("R7 interrupt", 32'(c_irq), 32'(e_irq));
      chk("R9 no frame error", 32'(c_fer), 0);
    end
    repeat (4) @(negedge clk);
  endtask

  // Drive a raw frame on rxd; stop bit low only for 12 cycles when bad.
  task automatic send_raw(input logic [8:0] bits, input int nb, input logic stop_ok,
                          output bit got, output logic [8:0] dat, output logic adr,
                          output logic mat, output logic fer);
    int tot;
    got = 0; dat = '0; adr = 0; mat = 0; fer = 0;
    tot = (nb + 2) * 16 + 40;
    for (int i = 0; i < tot; i++) begin
      if (i < 16) drv_line = 1'b0;
      else if (i < 16 * (nb + 1)) drv_line = bits[(i - 16) / 16];
      else if (i < 16 * (nb + 2)) drv_line = stop_ok ? 1'b1 : (i >= 16 * (nb + 1) + 12);
      else drv_line = 1'b1;
      @(negedge clk);
      if (rx_valid) begin
        got = 1; dat = rx_data; adr = rx_is_addr; mat = rx_match; fer = rx_frame_err;
      end
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done_flag) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    bit g;
    logic [8:0] dd;
    logic aa, mm, fe;
    rst_n = 1'b0; tick = 1'b0;
    net_en = 0; tx9_en = 0; rx9_en = 0; wlen9 = 0; drv_en = 1; addr_pol = 1; irq_en = 0;
    station = 8'h5A; tx_start = 0; tx_addr = 0; tx_data = '0; loop = 1; drv_line = 1;
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", 32'(tx_busy), 0);
    chk("R10 txd after reset", 32'(txd), 1);
    chk("R10 rx_valid after reset", 32'(rx_valid), 0);
    chk("R10 irq after reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    repeat (4) @(negedge clk);

    // R1: bit-level waveform of 0xA5
    @(negedge clk);
    tx_data = 9'h0A5; tx_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_start = 1'b0;
    repeat (7) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      logic e;
      e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : tx_data[k - 1];
      chk("R1 bit level", 32'(txd), 32'(e));
      repeat (16) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk("R1 idle high", 32'(txd), 1);

    // R2: every byte value in 8-bit mode
    set_cfg(0, 0, 0, 0, 1, 0);
    for (int v = 0; v < 256; v++) run_char(9'(v) | 9'h100, 1'b0, 1, 0);

    // R2: nine data bits
    set_cfg(0, 0, 0, 1, 1, 0);
    for (int k = 0; k < 48; k++) run_char(9'((k * 53 + 7) % 512), 1'b0, 1, 0);

    // R3 R4: marker enables without network mode have no effect
    set_cfg(0, 1, 1, 0, 1, 1);
    for (int k = 0; k < 16; k++) run_char(9'((k * 97 + 90) % 512), 1'b1, 1, 0);
    set_cfg(0, 1, 1, 1, 1, 1);
    for (int k = 0; k < 16; k++) run_char(9'((k * 61 + 3) % 512), 1'b1, 1, 0);

    // R3 R4: network mode without marker enables uses word length
    set_cfg(1, 0, 0, 1, 1, 1);
    for (int k = 0; k < 16; k++) run_char(9'((k * 29 + 11) % 512), 1'b1, 1, 0);

    // R5 R6 R7: address mode, both polarities, interrupts on and off
    for (int p = 0; p < 2; p++) begin
      for (int ie = 0; ie < 2; ie++) begin
        set_cfg(1, 1, 1, 0, 1'(p), 1'(ie));
        for (int k = 0; k < 12; k++) begin
          logic [8:0] d;
          d = (k < 4) ? 9'h05A : 9'((k * 41 + 2) % 512);
          run_char(d, 1'(k % 2 == 0 || k == 1), 1, 0);
        end
      end
    end

    // R11: a second start mid-frame is ignored
    set_cfg(1, 1, 1, 0, 1, 1);
    run_char(9'h05A, 1'b1, 1, 1);
    set_cfg(0, 0, 0, 0, 1, 0);
    run_char(9'h033, 1'b0, 1, 1);

    // R8: driver released
    @(negedge clk); drv_en = 1'b0;
    chk("R8 oe low", 32'(txd_oe), 0);
    run_char(9'h055, 1'b0, 0, 0);
    @(negedge clk); drv_en = 1'b1;
    chk("R8 oe high", 32'(txd_oe), 1);

    // R9: bad stop bit, then good stop bit
    loop = 1'b0;
    set_cfg(0, 0, 0, 0, 1, 0);
    send_raw(9'h0C3, 8, 1'b0, g, dd, aa, mm, fe);
    chk("R9 errored char delivered", 32'(g), 1);
    chk("R9 errored char data", 32'(dd), 32'h0C3);
    chk("R9 frame error set", 32'(fe), 1);
    send_raw(9'h03C, 8, 1'b1, g, dd, aa, mm, fe);
    chk("R9 good char data", 32'(dd), 32'h03C);
    chk("R9 frame error cleared", 32'(fe), 0);

    // R5: ninth bit opposite to polarity is data, not address
    set_cfg(1, 0, 1, 0, 1, 1);
    send_raw(9'h05A, 9, 1'b1, g, dd, aa, mm, fe);
    chk("R5 wrong ninth is data", 32'(aa), 0);
    chk("R6 data never matches", 32'(mm), 0);
    send_raw(9'h15A, 9, 1'b1, g, dd, aa, mm, fe);
    chk("R5 ninth equals pol is address", 32'(aa), 1);
    chk("R6 station match", 32'(mm), 1);
    set_cfg(1, 0, 1, 0, 0, 1);
    send_raw(9'h05A, 9, 1'b1, g, dd, aa, mm, fe);
    chk("R5 low polarity address", 32'(aa), 1);
    chk("R6 low polarity match", 32'(mm), 1);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule